// File: doc/BRIEF.md
# Half-Band Rate-Change FIR Filter

This block is a linear-phase low-pass filter with 55 fixed taps arranged as a half-band response: apart from the centre tap, only taps at an odd distance from the centre are non-zero. It takes one 12-bit signed sample per clock. It runs in one of three modes chosen at run time: same-rate filtering, 2:1 decimation or 1:2 interpolation. Its response falls to about -6 dB at a quarter of the sample rate.

In interpolation the clock runs at the output rate. Every second clock slot carries a real sample, and the other slot feeds a zero into the filter. In decimation every input is filtered, but only every second result is flagged valid. A sync input fixes which slot is the real or kept one. The output is the full-precision tap sum, which is meant for a separate rounding stage downstream. A change of mode clears all filter state.

Top module: `hbf_filter_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, every delay-line and pipeline register is cleared. After that edge acc_out is 0 and out_valid is 0, and the mode decoded at that edge becomes the held mode.
- R2: Mode decode: decim_sel=1 with interp_sel=0 selects decimation, and interp_sel=1 with decim_sel=0 selects interpolation. When both are equal (both 0 or both 1), the mode is same-rate filtering.
- R3: Let s(m) be the value shifted into the delay line at edge m. After edge n, acc_out equals the sum over k=0..54 of h[k]*s(n-7-k). Samples older than the last clear count as zero.
- R4: The coefficients are h[27]=16384. For odd j, h[27-j]=h[27+j]=c(j), where c(1..27 odd) = 10300, -3300, 1850, -1180, 790, -530, 350, -225, 138, -80, 43, -20, 8, -3. For even j other than 0, the coefficient is zero. An impulse entered at edge E therefore first shows at E+7, ends at E+61 and peaks at E+34.
- R5: In same-rate mode every input is shifted in, and out_valid is 1 after every edge from the 8th edge after the last clear onwards.
- R6: Each edge has a slot bit. Without sync, the slot alternates between 0 and 1 from edge to edge, and the first edge after a clear is slot 0. In decimation, the result formed after edge m is flagged valid (7 edges later) only if edge m was slot 0.
- R7: When sync_in is 1 at an edge, that edge is slot 0, whatever the previous slot was.
- R8: In interpolation, din is shifted in on slot-0 edges. On slot-1 edges a zero is shifted in and din has no effect. out_valid is 1 from the 8th edge after the last clear on.
- R9: At an edge where the decoded mode differs from the held mode, all state is cleared, that edge's din is discarded and the new mode is held. out_valid stays 0 after that edge and the 7 edges that follow it.
- R10: acc_out carries the exact tap sum without wrap for every input sequence. Its magnitude never exceeds 54018*2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous reset, active low |
| interp_sel | input | 1 | Interpolation select |
| decim_sel | input | 1 | Decimation select |
| sync_in | input | 1 | Forces the current edge to slot 0 |
| din | input | 12 | Two's complement input sample |
| acc_out | output | 32 | Full-precision signed filter sum |
| out_valid | output | 1 | Marks a result that belongs to the output stream |

## Verification
A single impulse in same-rate mode separates correct tap order and latency from shifted or mirrored coefficient wiring. It probes the first, zero-valued, neighbour-of-centre, peak and last taps at their exact cycles. A constant full-scale input checks the DC sum. A sign-matched extreme sequence drives the sum to its negative bound, which exposes an accumulator that is too narrow. Random streams with scattered sync pulses in decimation and interpolation catch slot-phase errors, and a large value fed only in zero slots catches a filter that lets din leak through. Each mode switch is checked for the all-zero, invalid interval that follows a flush.

// File: rtl/hbf_pkg.sv
`timescale 1ns/1ps
// Shared constants, mode type and fixed coefficient set of the half-band filter.
// Assumes the tap count is 4*k+3 so the outermost taps sit at an odd offset.
package hbf_pkg;

    localparam int TAPS      = 55;
    localparam int CENTRE    = (TAPS - 1) / 2;
    localparam int NPAIR     = (CENTRE + 1) / 2;
    localparam int NLEAF     = 1 << $clog2(NPAIR + 1);
    localparam int TREE_LVL  = $clog2(NLEAF);
    // pre-add, multiply, adder tree levels, output register
    localparam int LATENCY   = 3 + TREE_LVL;
    localparam int COEF_W    = 16;

    typedef enum logic [1:0] {
        MODE_SAME   = 2'd0,
        MODE_DECIM  = 2'd1,
        MODE_INTERP = 2'd2
    } hbf_mode_e;

    localparam logic signed [COEF_W-1:0] CENTRE_COEF = 16'sd16384;

    // Coefficient of the symmetric pair at offset 2*i+1 from the centre.
    function automatic logic signed [COEF_W-1:0] pair_coef(input int i);
        case (i)
            0:       pair_coef = 16'sd10300;
            1:       pair_coef = -16'sd3300;
            2:       pair_coef = 16'sd1850;
            3:       pair_coef = -16'sd1180;
            4:       pair_coef = 16'sd790;
            5:       pair_coef = -16'sd530;
            6:       pair_coef = 16'sd350;
            7:       pair_coef = -16'sd225;
            8:       pair_coef = 16'sd138;
            9:       pair_coef = -16'sd80;
            10:      pair_coef = 16'sd43;
            11:      pair_coef = -16'sd20;
            12:      pair_coef = 16'sd8;
            13:      pair_coef = -16'sd3;
            default: pair_coef = 16'sd0;
        endcase
    endfunction

    // Sum of coefficient magnitudes over all taps.
    function automatic longint abs_coef_sum();
        longint s;
        s = longint'(CENTRE_COEF);
        for (int i = 0; i < NPAIR; i++) begin
            s += 2 * ((pair_coef(i) < 0) ? -longint'(pair_coef(i)) : longint'(pair_coef(i)));
        end
        return s;
    endfunction

endpackage

// File: rtl/hbf_rate_ctrl.sv
`timescale 1ns/1ps
// Mode decode, slot phase and zero insertion for the half-band filter.
// Holds the active mode. Raises flush for one cycle when the requested mode
// differs from it. Produces the sample to shift in and the per-edge keep flag.
// Assumes sync_in and the select inputs are synchronous to clk.
module hbf_rate_ctrl
    import hbf_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   interp_sel,
    input  logic                   decim_sel,
    input  logic                   sync_in,
    input  logic signed [IN_W-1:0] din,
    output logic                   flush,
    output logic                   slot,
    output logic                   keep,
    output logic signed [IN_W-1:0] shift_val,
    output hbf_mode_e              mode_q
);

    hbf_mode_e mode_req;
    logic      slot_q;

    // Decode the two select pins into a mode; equal pins mean same rate.
    always_comb begin
        if (interp_sel == decim_sel) mode_req = MODE_SAME;
        else if (decim_sel)          mode_req = MODE_DECIM;
        else                         mode_req = MODE_INTERP;
    end

    // Slot phase, zero insertion and keep flag for the current edge.
    always_comb begin
        flush     = (mode_req != mode_q);
        slot      = sync_in ? 1'b0 : ~slot_q;
        shift_val = (mode_req == MODE_INTERP && slot) ? '0 : din;
        keep      = (mode_req != MODE_DECIM) || !slot;
    end

    // Hold the mode and the previous slot; a clear restarts the phase at slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            mode_q <= mode_req;
            slot_q <= 1'b1;
        end else begin
            slot_q <= slot;
        end
    end

    // R6
    slot_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (sync_in || slot != $past(slot)));

    // R7
    sync_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |-> !slot);

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> $stable(mode_q));

endmodule

// File: rtl/hbf_delay_line.sv
`timescale 1ns/1ps
// Tapped shift register holding the most recent samples; tap 0 is newest.
// A flush or reset clears every tap in the same cycle.
module hbf_delay_line #(
    parameter int W     = 12,
    parameter int DEPTH = 55
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic signed [W-1:0] shift_in,
    output logic signed [W-1:0] taps [DEPTH]
);

    // Shift one place per clock, or clear on flush/reset.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            taps <= '{default: '0};
        end else begin
            taps[0] <= shift_in;
            for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
        end
    end

    // R3
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (taps[0] == $past(shift_in) && taps[DEPTH-1] == $past(taps[DEPTH-2])));

    // R9
    flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (taps[0] == '0 && taps[DEPTH/2] == '0 && taps[DEPTH-1] == '0));

endmodule

// File: rtl/hbf_symmac.sv
`timescale 1ns/1ps
// Symmetric half-band multiply-accumulate. Pre-adds mirrored taps, multiplies
// each pair and the centre tap by fixed coefficients, then sums the products
// in a registered binary tree. Latency from the tap state to acc is LATENCY.
// Assumes ACC_W holds the full tap sum.
module hbf_symmac
    import hbf_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic signed [IN_W-1:0]  taps [TAPS],
    output logic signed [ACC_W-1:0] acc
);

    localparam int PRE_W = IN_W + 1;
    localparam logic signed [ACC_W-1:0] ACC_BOUND =
        ACC_W'(abs_coef_sum() * (longint'(1) << (IN_W - 1)));

    logic signed [PRE_W-1:0] pre_c  [NPAIR+1];
    logic signed [PRE_W-1:0] pre_q  [NPAIR+1];
    logic signed [ACC_W-1:0] prod_c [NLEAF];
    logic signed [ACC_W-1:0] node   [1:2*NLEAF-1];

    // Pre-adders for each mirrored tap pair at odd offset.
    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        localparam int OFF = 2 * i + 1;
        assign pre_c[i] = {taps[CENTRE-OFF][IN_W-1], taps[CENTRE-OFF]}
                        + {taps[CENTRE+OFF][IN_W-1], taps[CENTRE+OFF]};
    end
    assign pre_c[NPAIR] = {taps[CENTRE][IN_W-1], taps[CENTRE]};

    // One multiplier per leaf; spare leaves of the power-of-two tree are zero.
    for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
        if (i < NPAIR) begin : g_pair_mul
            localparam logic signed [ACC_W-1:0] K = ACC_W'(pair_coef(i));
            assign prod_c[i] = ACC_W'(pre_q[i]) * K;
        end else if (i == NPAIR) begin : g_centre_mul
            localparam logic signed [ACC_W-1:0] K = ACC_W'(CENTRE_COEF);
            assign prod_c[i] = ACC_W'(pre_q[i]) * K;
        end else begin : g_pad
            assign prod_c[i] = '0;
        end
    end

    // Pre-add, product and tree registers; cleared together on flush/reset.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            pre_q <= '{default: '0};
            node  <= '{default: '0};
            acc   <= '0;
        end else begin
            pre_q <= pre_c;
            for (int i = 0; i < NLEAF; i++) node[NLEAF+i] <= prod_c[i];
            for (int n = 1; n < NLEAF; n++) node[n] <= node[2*n] + node[2*n+1];
            acc <= node[1];
        end
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc <= ACC_BOUND && acc >= -ACC_BOUND));

    // R9
    mac_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (acc == '0 && node[1] == '0));

endmodule

// File: rtl/hbf_filter_top.sv
`timescale 1ns/1ps
// Top of the half-band rate-change filter. Joins rate control, delay line
// and multiply-accumulate, and delays the keep flag to match the datapath.
// Assumes one input sample per clock; interpolation uses the clock as the
// output rate.
module hbf_filter_top
    import hbf_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    interp_sel,
    input  logic                    decim_sel,
    input  logic                    sync_in,
    input  logic signed [IN_W-1:0]  din,
    output logic signed [ACC_W-1:0] acc_out,
    output logic                    out_valid
);

    localparam int CNT_W   = $clog2(LATENCY + 3) + 1;
    localparam int CNT_SAT = LATENCY + 2;

    logic                   flush;
    logic                   slot;
    logic                   keep;
    logic signed [IN_W-1:0] shift_val;
    hbf_mode_e              mode_q;
    logic signed [IN_W-1:0] tap_w [TAPS];
    logic [LATENCY:0]       vpipe;

    hbf_rate_ctrl #(.IN_W(IN_W)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .interp_sel (interp_sel),
        .decim_sel  (decim_sel),
        .sync_in    (sync_in),
        .din        (din),
        .flush      (flush),
        .slot       (slot),
        .keep       (keep),
        .shift_val  (shift_val),
        .mode_q     (mode_q)
    );

    hbf_delay_line #(.W(IN_W), .DEPTH(TAPS)) u_dline (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .shift_in (shift_val),
        .taps     (tap_w)
    );

    hbf_symmac #(.IN_W(IN_W), .ACC_W(ACC_W)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .taps  (tap_w),
        .acc   (acc_out)
    );

    // Carry the keep flag alongside the datapath so it lines up with acc_out.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) vpipe <= '0;
        else                 vpipe <= {vpipe[LATENCY-1:0], keep};
    end

    assign out_valid = vpipe[LATENCY];

    // Checker state: cycles since the last clear, and since the last clear or sync.
    logic [CNT_W-1:0] quiet_cnt;
    logic [CNT_W-1:0] nosync_cnt;

    // Count cycles since clear and since sync, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            quiet_cnt  <= '0;
            nosync_cnt <= '0;
        end else begin
            if (quiet_cnt != CNT_W'(CNT_SAT)) quiet_cnt <= quiet_cnt + 1'b1;
            if (sync_in)                          nosync_cnt <= '0;
            else if (nosync_cnt != CNT_W'(CNT_SAT)) nosync_cnt <= nosync_cnt + 1'b1;
        end
    end

    // R5
    same_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SAME && quiet_cnt > CNT_W'(LATENCY)) |-> out_valid);

    // R8
    interp_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_INTERP && quiet_cnt > CNT_W'(LATENCY)) |-> out_valid);

    // R8
    interp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_INTERP && !flush && slot) |=> tap_w[0] == '0);

    // R6
    decim_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DECIM && nosync_cnt > CNT_W'(LATENCY + 1) && out_valid) |=> !out_valid);

    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_cnt <= CNT_W'(LATENCY)) |-> !out_valid);

endmodule

// File: tb/tb_hbf_filter_top.sv
`timescale 1ns/1ps
// Scoreboard bench: drive() updates a reference model after every edge and
// queues the expected output; the monitor pops the entry from 7 edges earlier.
module tb_hbf_filter_top;

    localparam int LAT = 7;
    localparam int NT  = 55;

    typedef struct {
        bit     v;
        longint a;
    } item_t;

    logic               clk;
    logic               rst_n;
    logic               interp_sel;
    logic               decim_sel;
    logic               sync_in;
    logic signed [11:0] din;
    logic signed [31:0] acc_out;
    logic               out_valid;

    int     n_checks = 0;
    int     n_fail   = 0;
    string  tag      = "R1";
    item_t  sbq[$];
    longint hist[NT];
    int     m_mode   = 0;
    bit     m_slot   = 1'b1;

    hbf_filter_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .interp_sel (interp_sel),
        .decim_sel  (decim_sel),
        .sync_in    (sync_in),
        .din        (din),
        .acc_out    (acc_out),
        .out_valid  (out_valid)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Coefficients as listed in R4.
    function automatic longint hc(input int k);
        int off;
        off = (k > 27) ? k - 27 : 27 - k;
        if (off == 0) return 16384;
        if (off % 2 == 0) return 0;
        case ((off - 1) / 2)
            0: return 10300;   1: return -3300;  2: return 1850;  3: return -1180;
            4: return 790;     5: return -530;   6: return 350;   7: return -225;
            8: return 138;     9: return -80;    10: return 43;   11: return -20;
            12: return 8;      default: return -3;
        endcase
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one cycle of inputs, then advance the reference model (R2, R3, R6-R9).
    task automatic drive(input int x, input bit ip, input bit dc, input bit sy, input bit rst);
        int    md;
        bit    slot;
        bit    keep;
        longint s;
        longint acc;
        item_t it;
        rst_n = ~rst; din = 12'(x); interp_sel = ip; decim_sel = dc; sync_in = sy;
        @(posedge clk);
        #1;
        md = (ip == dc) ? 0 : (dc ? 1 : 2);
        if (rst || md != m_mode) begin
            m_mode = md;
            m_slot = 1'b1;
            foreach (hist[k]) hist[k] = 0;
            foreach (sbq[q]) sbq[q] = '{1'b0, 0};
            it = '{1'b0, 0};
        end else begin
            slot = sy ? 1'b0 : ~m_slot;
            m_slot = slot;
            s = (md == 2 && slot) ? 0 : longint'(x);
            for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = s;
            keep = (md != 1) || !slot;
            acc = 0;
            for (int k = 0; k < NT; k++) acc += hc(k) * hist[k];
            it = '{keep, acc};
        end
        sbq.push_back(it);
    endtask

    // Monitor: compare the outputs after edge n with the entry queued for edge n-7.
    always @(negedge clk) begin
        item_t it;
        if (sbq.size() > LAT) begin
            it = sbq.pop_front();
            check({tag, " valid"}, longint'(out_valid), longint'(it.v));
            check({tag, " sum"}, longint'(acc_out), it.a);
        end
    end

    // Watchdog: an expired timer counts as a failure.
    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int     cnt;
        longint ext;
        bit     leak;
        for (int i = 0; i < LAT; i++) sbq.push_back('{1'b0, 0});
        foreach (hist[k]) hist[k] = 0;

        // R1: reset state
        tag = "R1";
        drive(0, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 1);
        check("R1 valid", longint'(out_valid), 0);
        check("R1 sum", longint'(acc_out), 0);

        // R4: impulse timing and tap values
        tag = "R4";
        drive(1000, 0, 0, 0, 0);
        for (int i = 1; i <= 64; i++) begin
            drive(0, 0, 0, 0, 0);
            if (i == 6)  check("R4 before first tap", longint'(acc_out), 0);
            if (i == 7)  check("R4 first tap", longint'(acc_out), -3000);
            if (i == 8)  check("R4 zero tap", longint'(acc_out), 0);
            if (i == 33) check("R4 centre neighbour", longint'(acc_out), 10300000);
            if (i == 34) check("R4 peak", longint'(acc_out), 16384000);
            if (i == 61) check("R4 last tap", longint'(acc_out), -3000);
            if (i == 62) check("R4 after last tap", longint'(acc_out), 0);
        end

        // R3: random stream in same-rate mode
        tag = "R3";
        for (int i = 0; i < 80; i++) drive($urandom_range(0, 4095) - 2048, 0, 0, 0, 0);

        // R5: constant full scale, DC sum and steady valid
        tag = "R5";
        for (int i = 0; i < 70; i++) drive(2047, 0, 0, 0, 0);
        check("R5 valid", longint'(out_valid), 1);
        check("R5 dc sum", longint'(acc_out), 2047 * 32666);

        // R10: sign-matched extreme pattern reaching the negative bound
        tag = "R10";
        ext = 0;
        for (int idx = NT - 1; idx >= 0; idx--) begin
            drive((hc(idx) < 0) ? 2047 : -2048, 0, 0, 0, 0);
            ext += hc(idx) * ((hc(idx) < 0) ? 2047 : -2048);
        end
        for (int i = 0; i < LAT; i++) drive(0, 0, 0, 0, 0);
        check("R10 extreme sum", longint'(acc_out), ext);

        // R9: switch to decimation flushes state
        tag = "R9";
        drive(1500, 0, 1, 0, 0);
        check("R9 sum after flush", longint'(acc_out), 0);
        check("R9 valid after flush", longint'(out_valid), 0);
        for (int i = 1; i <= LAT; i++) begin
            drive($urandom_range(0, 4095) - 2048, 0, 1, 0, 0);
            check("R9 quiet valid", longint'(out_valid), 0);
        end
        drive($urandom_range(0, 4095) - 2048, 0, 1, 0, 0);
        check("R9 first valid", longint'(out_valid), 1);

        // R6: decimation keeps every second result
        tag = "R6";
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            drive($urandom_range(0, 4095) - 2048, 0, 1, 0, 0);
            cnt += int'(out_valid);
        end
        check("R6 kept count", cnt, 20);

        // R7: sync on two consecutive edges keeps both
        tag = "R7";
        drive($urandom_range(0, 4095) - 2048, 0, 1, 1, 0);
        drive($urandom_range(0, 4095) - 2048, 0, 1, 1, 0);
        for (int i = 2; i <= 9; i++) begin
            drive($urandom_range(0, 4095) - 2048, 0, 1, 0, 0);
            if (i == 7) check("R7 sync kept", longint'(out_valid), 1);
            if (i == 8) check("R7 second sync kept", longint'(out_valid), 1);
            if (i == 9) check("R7 following slot dropped", longint'(out_valid), 0);
        end
        for (int i = 0; i < 40; i++)
            drive($urandom_range(0, 4095) - 2048, 0, 1, ($urandom_range(0, 7) == 0), 0);

        // R8: interpolation ignores din in zero slots
        tag = "R8";
        drive(0, 1, 0, 0, 0);
        leak = 1'b0;
        for (int i = 0; i < 70; i++) begin
            drive((i % 2 == 0) ? 0 : 2000, 1, 0, 0, 0);
            if (acc_out != 0) leak = 1'b1;
        end
        check("R8 zero-slot din ignored", longint'(leak), 0);
        check("R8 valid", longint'(out_valid), 1);
        for (int i = 0; i < 100; i++)
            drive($urandom_range(0, 4095) - 2048, 1, 0, ($urandom_range(0, 7) == 0), 0);

        // R2: both selects high means same-rate mode
        tag = "R2";
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            drive($urandom_range(0, 4095) - 2048, 1, 1, (i % 5 == 0), 0);
            if (i >= 8) cnt += int'(out_valid);
        end
        check("R2 both-high same rate", cnt, 22);

        drive(0, 1, 1, 0, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule